// File: doc/BRIEF.md
# Scanline Interrupt Down-Counter with Mirrored Control Window

This block counts video scanlines and raises an interrupt request after a programmed number of them. A processor programs it through single-cycle register writes. The same four controls respond at two address windows: a high window decoded on address bits 15:13 and bit 0, and a low alias window of four consecutive addresses. The video side supplies a one-cycle strobe per scanline and a level input that says whether rendering is on. Strobes count only while rendering is on.

The counter reloads from an 8-bit period register, which always has bit 0 cleared. It then counts down once per strobe. When the count reaches zero and interrupts are enabled, a sticky request is raised. The request stays high until software disables interrupts or the block is reset. The most significant bit of the period register is stored and counted like any other bit; this block has no alternative counting mode. The counter value is brought out only so that a test can observe it.

Register writes are plain strobes with no handshake: every write is accepted in the cycle it appears, and there is no back-pressure. The interrupt and count outputs are plain status pins.

Top module: `scanline_irq_ctr`

## Requirements
- R1: After reset, `irq` is 0 and `count_q` is 0, the period register is 0, and no reload is pending.
- R2: A write to address 0xC000 or to the alias base + 1 (0x4101 by default) loads the period register with the written data with bit 0 cleared, so a written 0x07 loads 6.
- R3: A write to 0xC001 or the alias base + 2 schedules a reload whatever the data is. The next counted strobe loads `count_q` from the period register and cancels the reload.
- R4: On a counted strobe with no reload scheduled, `count_q` is reloaded from the period register if it was 0, and is decremented by one otherwise.
- R5: After a counted strobe, if `count_q` is 0 and interrupts are enabled, `irq` goes to 1 at that same clock edge. It then stays 1 through any later strobes until it is disabled or reset.
- R6: A write to 0xE000 or the alias base + 3 clears the enable and drops `irq` to 0 at the next edge.
- R7: A write to 0xE001 or the alias base + 4 sets the enable.
- R8: A strobe while `render_en` is 0 changes neither `count_q`, `irq`, nor the scheduled reload.
- R9: When a write and a counted strobe arrive in the same cycle, the write is applied first and the strobe sees the updated period, reload flag and enable.
- R10: The high window decodes only address bits 15:13 and bit 0, so 0xC002 acts as 0xC000. Writes elsewhere, such as 0x8000, 0xA001, 0x4100, 0x4105 or 0x6001, change no state.
- R11: With a period of 0, `irq` rises on the first counted strobe after a reload. With a period of 4, it rises on the fifth.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle register write strobe |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data |
| line_strobe | input | 1 | One-cycle pulse per scanline |
| render_en | input | 1 | Strobes are counted only while this is 1 |
| irq | output | 1 | Active-high registered interrupt request |
| count_q | output | 8 | Current count, for observation only |

## Verification
The counter is driven with periods of 4, 6 (written as an odd value), and 0. This separates a reload-then-count sequence from a wrap-around reload, and shows that bit 0 of the written period is dropped. Strobes are sent with rendering off, and writes go to neighbouring, mirrored and unused addresses. These two patterns show which inputs the block ignores and which addresses it decodes. Writes that coincide with a counting strobe (reload, enable, disable) tell a design that applies the write first apart from one that lets the strobe see stale flags. A behavioural model compared on every clock catches any divergence between these targeted checks.

// File: rtl/irq_ctr_pkg.sv
package irq_ctr_pkg;
  typedef enum logic [2:0] {
    CMD_NONE    = 3'd0,
    CMD_PERIOD  = 3'd1,
    CMD_RELOAD  = 3'd2,
    CMD_DISABLE = 3'd3,
    CMD_ENABLE  = 3'd4
  } ctr_cmd_e;
endpackage

// File: rtl/irq_win_decode.sv
module irq_win_decode
  import irq_ctr_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter bit          ALIAS_ON   = 1'b1,
  parameter logic [15:0] ALIAS_BASE = 16'h4100
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  output ctr_cmd_e          cmd
);
  localparam int TOP = ADDR_W - 1;

  ctr_cmd_e hi_cmd;
  ctr_cmd_e lo_cmd;

  // High window: bits [TOP:TOP-2] pick the group, bit 0 picks the pair member.
  always_comb begin
    hi_cmd = CMD_NONE;
    unique case ({wr_addr[TOP:TOP-2], wr_addr[0]})
      4'b1100: hi_cmd = CMD_PERIOD;
      4'b1101: hi_cmd = CMD_RELOAD;
      4'b1110: hi_cmd = CMD_DISABLE;
      4'b1111: hi_cmd = CMD_ENABLE;
      default: hi_cmd = CMD_NONE;
    endcase
  end

  generate
    if (ALIAS_ON) begin : g_alias
      logic base_hit;
      assign base_hit = (wr_addr[TOP:4] == ALIAS_BASE[TOP:4]);
      always_comb begin
        lo_cmd = CMD_NONE;
        if (base_hit) begin
          unique case (wr_addr[3:0])
            4'h1:    lo_cmd = CMD_PERIOD;
            4'h2:    lo_cmd = CMD_RELOAD;
            4'h3:    lo_cmd = CMD_DISABLE;
            4'h4:    lo_cmd = CMD_ENABLE;
            default: lo_cmd = CMD_NONE;
          endcase
        end
      end
    end else begin : g_no_alias
      assign lo_cmd = CMD_NONE;
    end
  endgenerate

  always_comb begin
    if (!wr_en)                 cmd = CMD_NONE;
    else if (hi_cmd != CMD_NONE) cmd = hi_cmd;
    else                         cmd = lo_cmd;
  end
endmodule

// File: rtl/irq_line_counter.sv
module irq_line_counter
  import irq_ctr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctr_cmd_e         cmd,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             tick,
  output logic [CNT_W-1:0] count_q,
  output logic             pend_q
);
  localparam logic [CNT_W-1:0] EVEN_MASK = {{(CNT_W-1){1'b1}}, 1'b0};
  localparam logic [CNT_W-1:0] ZERO      = '0;

  logic [CNT_W-1:0] period_q, period_w, count_n;
  logic             reload_q, reload_w, reload_n;
  logic             en_q, en_w;
  logic             pend_w, pend_n;

  // Stage 1: apply the processor write.
  always_comb begin
    period_w = (cmd == CMD_PERIOD) ? (wr_data & EVEN_MASK) : period_q;
    reload_w = reload_q | (cmd == CMD_RELOAD);
    en_w     = (cmd == CMD_ENABLE) ? 1'b1 : (cmd == CMD_DISABLE) ? 1'b0 : en_q;
    pend_w   = (cmd == CMD_DISABLE) ? 1'b0 : pend_q;
  end

  // Stage 2: the scanline strobe sees the post-write state.
  always_comb begin
    count_n  = count_q;
    reload_n = reload_w;
    pend_n   = pend_w;
    if (tick) begin
      if (reload_w) begin
        count_n  = period_w;
        reload_n = 1'b0;
      end else if (count_q == ZERO) begin
        count_n = period_w;
      end else begin
        count_n = count_q - 1'b1;
      end
      pend_n = pend_w | ((count_n == ZERO) & en_w);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period_q <= '0;
      count_q  <= '0;
      reload_q <= 1'b0;
      en_q     <= 1'b0;
      pend_q   <= 1'b0;
    end else begin
      period_q <= period_w;
      count_q  <= count_n;
      reload_q <= reload_n;
      en_q     <= en_w;
      pend_q   <= pend_n;
    end
  end

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(count_q));

  a_r6_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_DISABLE) |=> !pend_q);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && cmd != CMD_DISABLE) |=> pend_q);

  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !reload_q && cmd != CMD_RELOAD && count_q != ZERO)
      |=> (count_q == $past(count_q) - 1'b1));

  a_r2_period_even: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reload_q) |=> !count_q[0]);
endmodule

// File: rtl/scanline_irq_ctr.sv
module scanline_irq_ctr
  import irq_ctr_pkg::*;
#(
  parameter int          CNT_W      = 8,
  parameter int          ADDR_W     = 16,
  parameter bit          ALIAS_ON   = 1'b1,
  parameter logic [15:0] ALIAS_BASE = 16'h4100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              line_strobe,
  input  logic              render_en,
  output logic              irq,
  output logic [CNT_W-1:0]  count_q
);
  ctr_cmd_e cmd;
  logic     tick;

  assign tick = line_strobe & render_en;

  irq_win_decode #(
    .ADDR_W(ADDR_W), .ALIAS_ON(ALIAS_ON), .ALIAS_BASE(ALIAS_BASE)
  ) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .cmd(cmd)
  );

  irq_line_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .wr_data(wr_data),
    .tick(tick), .count_q(count_q), .pend_q(irq)
  );

  a_r5_rise_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (count_q == '0));

  a_r8_render_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!render_en && !wr_en) |=> ($stable(irq) && $stable(count_q)));

  a_r10_no_write_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_en) |=> irq);
endmodule

// File: tb/scanline_irq_ctr_test.sv
module scanline_irq_ctr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        line_strobe = 1'b0;
  logic        render_en = 1'b0;
  logic        irq;
  logic [7:0]  count_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference state
  int m_period = 0, m_count = 0;
  bit m_reload = 0, m_en = 0, m_pend = 0;

  always #5 clk = ~clk;

  scanline_irq_ctr uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .line_strobe(line_strobe), .render_en(render_en),
    .irq(irq), .count_q(count_q)
  );

  function automatic int decode(input logic [15:0] a);
    // 1 period, 2 reload, 3 disable, 4 enable, 0 none
    if (a[15:13] == 3'b110) return a[0] ? 2 : 1;
    if (a[15:13] == 3'b111) return a[0] ? 4 : 3;
    if (a[15:4] == 12'h410 && a[3:0] >= 1 && a[3:0] <= 4) return int'(a[3:0]);
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_period = 0; m_count = 0; m_reload = 0; m_en = 0; m_pend = 0;
    end else begin
      if (wr_en) begin
        case (decode(wr_addr))
          1: m_period = wr_data & 8'hFE;
          2: m_reload = 1;
          3: begin m_en = 0; m_pend = 0; end
          4: m_en = 1;
          default: ;
        endcase
      end
      if (line_strobe && render_en) begin
        if (m_reload) begin m_count = m_period; m_reload = 0; end
        else if (m_count == 0) m_count = m_period;
        else m_count = m_count - 1;
        if (m_count == 0 && m_en) m_pend = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (irq !== m_pend || int'(count_q) != m_count) begin
        fails++;
        $display("FAIL model R1-R11 cycle compare: irq=%0b count=%0d expected irq=%0b count=%0d",
                 irq, count_q, m_pend, m_count);
      end
    end
  end

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic cyc(input bit we, input logic [15:0] a, input logic [7:0] d,
                     input bit ls, input bit re);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; line_strobe = ls; render_en = re;
    @(negedge clk);
    wr_en = 0; line_strobe = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    cyc(1, a, d, 0, 1);
  endtask

  task automatic line(input bit re);
    cyc(0, 16'h0000, 8'h00, 1, re);
  endtask

  task automatic finish_run;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq after reset", irq, 0);
    check("R1 count after reset", count_q, 0);

    // R2 R3 R7 R11: period 4 fires on fifth strobe
    wr(16'hC000, 8'h04);
    wr(16'hC001, 8'h5A);
    wr(16'hE001, 8'h00);
    line(1);
    check("R3 reload loads period", count_q, 4);
    check("R2 period via high window", count_q, 4);
    line(1); line(1); line(1);
    check("R4 decrement", count_q, 1);
    check("R11 no irq before fifth strobe", irq, 0);
    line(1);
    check("R11 irq on fifth strobe", irq, 1);
    line(1);
    check("R4 zero reloads from period", count_q, 4);
    check("R5 irq sticky", irq, 1);

    wr(16'hE000, 8'h00);
    check("R6 disable clears irq", irq, 0);
    repeat (4) line(1);
    check("R6 count reaches zero while disabled", count_q, 0);
    check("R6 no irq while disabled", irq, 0);

    // R2 alias, odd value masked
    wr(16'h4101, 8'h07);
    wr(16'h4102, 8'hFF);
    wr(16'h4104, 8'h00);
    line(1);
    check("R2 alias period bit0 cleared", count_q, 6);

    // R8 render off
    repeat (3) line(0);
    check("R8 render off holds count", count_q, 6);

    // R10 ignored addresses
    wr(16'h8000, 8'h46); wr(16'hA001, 8'h00); wr(16'h4100, 8'h02);
    wr(16'h4105, 8'h00); wr(16'h6001, 8'h00);
    line(1);
    check("R10 stray writes leave decrement", count_q, 5);
    wr(16'hC002, 8'h02);
    wr(16'hC003, 8'h00);
    line(1);
    check("R10 mirrored high window", count_q, 2);

    // R11 period 0
    wr(16'hC000, 8'h01);
    wr(16'hC001, 8'h00);
    line(1);
    check("R11 period 0 fires at once", irq, 1);
    check("R11 period 0 count", count_q, 0);
    wr(16'h4103, 8'h00);
    check("R6 alias disable", irq, 0);

    // R9 same-cycle: enable write with strobe at zero
    cyc(1, 16'hE001, 8'h00, 1, 1);
    check("R9 enable seen by same strobe", irq, 1);
    // disable with strobe at zero
    cyc(1, 16'hE000, 8'h00, 1, 1);
    check("R9 disable seen by same strobe", irq, 0);
    // period + reload with same strobe
    wr(16'hC000, 8'h0A);
    cyc(1, 16'hC001, 8'h00, 1, 1);
    check("R9 reload seen by same strobe", count_q, 10);
    cyc(1, 16'hC000, 8'h20, 1, 1);
    check("R9 period write then decrement", count_q, 9);

    // R1 reset mid-run
    wr(16'hE001, 8'h00);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    line(1);
    check("R1 period cleared by reset", count_q, 0);
    check("R1 enable cleared by reset", irq, 0);

    @(negedge clk);
    finish_run();
  end
endmodule